// File: doc/BRIEF.md
# Packed Attribute Word Unpacker

This block sits behind three register addresses of a vertex front end. Software writes four 24-bit floating-point components as three consecutive 32-bit words. Fields in this format cross word boundaries. The block collects the three words and cuts them back into an X/Y/Z/W vector. The components arrive in reverse order: W comes first. The block does no arithmetic on the values.

An index register decides where a finished vector goes. While the index is below the last slot, the vector is written into a default-attribute store at that index, and the index then steps by one. At the last slot the index stops moving. From then on, vectors fill an immediate-mode vertex buffer, one attribute slot per vector. When the slot that has just been filled is the configured maximum, the slot wraps to zero and a one-cycle start pulse tells the shader side that a complete vertex is ready. An index above the last slot is invalid: the vector is dropped and a sticky error flag is raised.

Top module: `attr_unpack`

## Requirements
- R1: Every third accepted write (`wr_en_i` high) since reset completes a vector. No other input resets or alters this word count, including a load of the index register.
- R2: With the three words written in order as A, B and C, the vector is taken as follows. W = A[31:8]. Z = {A[7:0], B[31:16]}. Y = {B[15:0], C[31:24]}. X = C[23:0].
- R3: `rd_data_o` shows store entry `rd_addr_i` combinationally, packed as {X, Y, Z, W} with X in bits [95:72] and W in bits [23:0]. Any address that the store cannot hold reads as zero.
- R4: When a vector completes while the index is below NUM_SLOTS-1 (15), the vector is written into that store entry and the index becomes one higher.
- R5: When a vector completes while the index is NUM_SLOTS (16) or more, the vector is discarded. The store and the index are unchanged, and `err_o` goes high and stays high until reset.
- R6: When a vector completes at index NUM_SLOTS-1, it is written into the immediate buffer at the current slot. The index stays at NUM_SLOTS-1 and the default store is left untouched.
- R7: After an immediate write, the slot advances by one if it was below `max_attr_i`. Otherwise the slot returns to zero and `vtx_ready_o` is high for exactly the one cycle after the completing write.
- R8: `idx_load_i` loads the index from `idx_load_val_i`. If a vector completes in the same cycle, the vector is routed with the index held before the load, and the loaded value replaces any increment.
- R9: Reset clears the word count, the index, the immediate slot, the error flag, the ready pulse and both storage arrays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one of the three packed-attribute addresses |
| wr_data_i | input | 32 | Write data |
| idx_load_i | input | 1 | Load the index register |
| idx_load_val_i | input | 5 | Value to load into the index |
| max_attr_i | input | 4 | Highest immediate attribute slot used by a vertex |
| rd_addr_i | input | 4 | Default store read address |
| rd_data_o | output | 96 | Default store read data {X,Y,Z,W} |
| imm_rd_addr_i | input | 4 | Immediate buffer read address |
| imm_rd_data_o | output | 96 | Immediate buffer read data {X,Y,Z,W} |
| idx_o | output | 5 | Current index |
| err_o | output | 1 | Sticky invalid-index flag |
| vtx_ready_o | output | 1 | One-cycle pulse when the immediate vertex is complete |

## Verification
Two events can meet in one cycle: an index load and the third word of a vector. The bench provokes this by raising `idx_load_i` on the same clock as a completing write. It then checks that the vector landed in the entry named by the old index, that the index reads back the loaded value rather than the increment, and that the entry named by the loaded value is unchanged. A load placed between the second and third words checks that the word count is not disturbed. The bench also lowers `max_attr_i` below the live slot and checks that the slot wraps and the ready pulse fires on that same completion.

// File: rtl/attr_unpack_pkg.sv
package attr_unpack_pkg;
  localparam int COMP_W = 24;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [COMP_W-1:0] x;
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] z;
    logic [COMP_W-1:0] w;
  } attr_vec_t;

  // Components arrive W first; fields straddle word edges.
  function automatic attr_vec_t unpack_words(input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b,
                                             input logic [WORD_W-1:0] c);
    attr_vec_t v;
    v.w = a[31:8];
    v.z = {a[7:0], b[31:16]};
    v.y = {b[15:0], c[31:24]};
    v.x = c[23:0];
    return v;
  endfunction
endpackage

// File: rtl/attr_word_collector.sv
module attr_word_collector
  import attr_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              vec_done_o,
  output attr_vec_t         vec_o
);
  localparam int WORDS = 3;
  localparam int CW    = $clog2(WORDS);
  localparam logic [CW-1:0] LAST_WORD = CW'(WORDS - 1);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] word0_q, word1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      word0_q <= '0;
      word1_q <= '0;
    end else if (wr_en_i) begin
      if (cnt_q == '0) word0_q <= wr_data_i;
      if (cnt_q == CW'(1)) word1_q <= wr_data_i;
      cnt_q <= (cnt_q == LAST_WORD) ? '0 : cnt_q + 1'b1;
    end
  end

  // Third word is taken straight from the bus.
  assign vec_done_o = wr_en_i && (cnt_q == LAST_WORD);
  assign vec_o      = unpack_words(word0_q, word1_q, wr_data_i);
endmodule

// File: rtl/attr_default_store.sv
module attr_default_store
  import attr_unpack_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  attr_vec_t     wdata_i,
  input  logic [AW-1:0] raddr_i,
  output attr_vec_t     rdata_o
);
  attr_vec_t mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[e] <= '0;
      else if (we_i && waddr_i == AW'(e)) mem_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < DEPTH; e++)
      if (raddr_i == AW'(e)) rdata_o = mem_q[e];
  end
endmodule

// File: rtl/attr_imm_assembler.sv
module attr_imm_assembler
  import attr_unpack_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  attr_vec_t     vec_i,
  input  logic [SW-1:0] max_i,
  input  logic [SW-1:0] rd_addr_i,
  output attr_vec_t     rd_data_o,
  output logic          ready_o
);
  logic [SW-1:0] slot_q;
  logic          ready_q;
  attr_vec_t     buf_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (push_i) begin
        if (slot_q < max_i) begin
          slot_q <= slot_q + 1'b1;
        end else begin
          slot_q  <= '0;
          ready_q <= 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[s] <= '0;
      else if (push_i && slot_q == SW'(s)) buf_q[s] <= vec_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rd_addr_i == SW'(s)) rd_data_o = buf_q[s];
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/attr_unpack.sv
module attr_unpack
  import attr_unpack_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IMM_SLOTS = 16,
  localparam int AW    = $clog2(NUM_SLOTS),
  localparam int IDX_W = AW + 1,
  localparam int SW    = $clog2(IMM_SLOTS),
  localparam int VW    = 4 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              idx_load_i,
  input  logic [IDX_W-1:0]  idx_load_val_i,
  input  logic [SW-1:0]     max_attr_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [VW-1:0]     rd_data_o,
  input  logic [SW-1:0]     imm_rd_addr_i,
  output logic [VW-1:0]     imm_rd_data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              err_o,
  output logic              vtx_ready_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic       vec_done;
  attr_vec_t  vec;
  attr_vec_t  store_rd, imm_rd;
  logic [IDX_W-1:0] idx_q;
  logic       err_q;
  logic       to_store, to_imm, to_bad;

  attr_word_collector u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .vec_done_o (vec_done),
    .vec_o      (vec)
  );

  assign to_store = vec_done && (idx_q <  LAST_IDX);
  assign to_imm   = vec_done && (idx_q == LAST_IDX);
  assign to_bad   = vec_done && (idx_q >  LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (idx_load_i)    idx_q <= idx_load_val_i;
      else if (to_store) idx_q <= idx_q + 1'b1;
      if (to_bad) err_q <= 1'b1;
    end
  end

  attr_default_store #(.DEPTH(NUM_SLOTS - 1), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (to_store),
    .waddr_i (idx_q[AW-1:0]),
    .wdata_i (vec),
    .raddr_i (rd_addr_i),
    .rdata_o (store_rd)
  );

  attr_imm_assembler #(.SLOTS(IMM_SLOTS), .SW(SW)) u_imm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (to_imm),
    .vec_i     (vec),
    .max_i     (max_attr_i),
    .rd_addr_i (imm_rd_addr_i),
    .rd_data_o (imm_rd),
    .ready_o   (vtx_ready_o)
  );

  assign rd_data_o     = store_rd;
  assign imm_rd_data_o = imm_rd;
  assign idx_o         = idx_q;
  assign err_o         = err_q;
endmodule

// File: rtl/attr_unpack_chk.sv
module attr_unpack_chk #(
  parameter int IDX_W     = 5,
  parameter int NUM_SLOTS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vec_done_i,
  input logic             idx_load_i,
  input logic [IDX_W-1:0] idx_load_val_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             err_i,
  input logic             ready_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  p_idx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_done_i && !idx_load_i && idx_i < LAST_IDX) |=> idx_i == IDX_W'($past(idx_i) + 1'b1));

  p_err_discard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_done_i && !idx_load_i && idx_i > LAST_IDX) |=> (err_i && $stable(idx_i)));

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  p_last_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_done_i && !idx_load_i && idx_i == LAST_IDX) |=> idx_i == LAST_IDX);

  p_ready_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> $past(vec_done_i && idx_i == LAST_IDX));

  p_ready_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  p_idx_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_load_i |=> idx_i == $past(idx_load_val_i));
endmodule

bind attr_unpack attr_unpack_chk #(.IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .vec_done_i     (vec_done),
  .idx_load_i     (idx_load_i),
  .idx_load_val_i (idx_load_val_i),
  .idx_i          (idx_o),
  .err_i          (err_o),
  .ready_i        (vtx_ready_o)
);

// File: tb/attr_unpack_tb.sv
module attr_unpack_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        idx_load;
  logic [4:0]  idx_val;
  logic [3:0]  max_attr;
  logic [3:0]  rd_addr, imm_addr;
  logic [95:0] rd_data, imm_data;
  logic [4:0]  idx;
  logic        err, ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  attr_unpack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .idx_load_i(idx_load), .idx_load_val_i(idx_val), .max_attr_i(max_attr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .imm_rd_addr_i(imm_addr),
    .imm_rd_data_o(imm_data), .idx_o(idx), .err_o(err), .vtx_ready_o(ready)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input int i, input int k);
    return 24'((i * 7919 + k * 104729 + 24'h5A3C1) ^ (k << 20));
  endfunction

  function automatic logic [95:0] vec_of(input int i);
    return {mk(i, 0), mk(i, 1), mk(i, 2), mk(i, 3)};
  endfunction

  task automatic write_word(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Packs {x,y,z,w} into three words; optional index load with the third word.
  task automatic send_vec(input logic [95:0] v, input bit ld, input logic [4:0] ldv,
                          output logic got_ready);
    logic [23:0] x, y, z, w;
    logic [31:0] words [3];
    {x, y, z, w} = v;
    words[0] = {w, z[23:16]};
    words[1] = {z[15:0], y[23:8]};
    words[2] = {y[7:0], x};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = words[k];
      if (k == 2 && ld) begin idx_load = 1'b1; idx_val = ldv; end
    end
    @(negedge clk);
    wr_en = 1'b0; idx_load = 1'b0;
    got_ready = ready;
  endtask

  task automatic load_idx(input logic [4:0] v);
    @(negedge clk);
    idx_load = 1'b1; idx_val = v;
    @(negedge clk);
    idx_load = 1'b0;
  endtask

  task automatic read_store(input logic [3:0] a, output logic [95:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic read_imm(input logic [3:0] a, output logic [95:0] d);
    imm_addr = a; #1; d = imm_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [95:0] d, saved;
    logic r;
    wr_en = 0; wr_data = 0; idx_load = 0; idx_val = 0; max_attr = 0;
    rd_addr = 0; imm_addr = 0;
    do_reset();

    // R9 reset state
    @(negedge clk);
    check("R9 idx", 96'(idx), 96'd0);
    check("R9 err", 96'(err), 96'd0);
    check("R9 ready", 96'(ready), 96'd0);
    read_store(4'd0, d); check("R9 store", d, 96'd0);
    read_imm(4'd0, d);   check("R9 imm", d, 96'd0);

    // R2 fixed pattern across word edges
    write_word(32'h11223344);
    write_word(32'h55667788);
    write_word(32'h99AABBCC);
    read_store(4'd0, d);
    check("R2 unpack", d, {24'hAABBCC, 24'h778899, 24'h445566, 24'h112233});
    check("R4 idx after first", 96'(idx), 96'd1);

    // R4/R3 auto-increment fill of entries 1..14
    for (int i = 1; i < 15; i++) begin
      send_vec(vec_of(i), 0, 5'd0, r);
      check("R4 idx step", 96'(idx), 96'(i + 1));
    end
    for (int i = 1; i < 15; i++) begin
      read_store(4'(i), d);
      check("R3 store readback", d, vec_of(i));
    end
    read_store(4'd15, d);
    check("R3 unbacked address", d, 96'd0);
    read_store(4'd14, saved);

    // R6/R7 immediate assembly sweep over max values
    for (int m = 0; m < 4; m++) begin
      max_attr = 4'(m);
      for (int n = 0; n <= m; n++) begin
        send_vec(vec_of(100 + m * 8 + n), 0, 5'd0, r);
        check("R7 ready pulse", 96'(r), 96'(n == m));
        read_imm(4'(n), d);
        check("R6 imm slot", d, vec_of(100 + m * 8 + n));
        check("R6 idx holds", 96'(idx), 96'd15);
        @(negedge clk);
        check("R7 pulse one cycle", 96'(ready), 96'd0);
      end
    end
    read_store(4'd14, d);
    check("R6 store untouched", d, saved);

    // R7 max lowered below the live slot
    max_attr = 4'd3;
    send_vec(vec_of(200), 0, 5'd0, r);
    send_vec(vec_of(201), 0, 5'd0, r);
    max_attr = 4'd1;
    send_vec(vec_of(202), 0, 5'd0, r);
    check("R7 wrap on lowered max", 96'(r), 96'd1);
    read_imm(4'd2, d); check("R7 slot2 data", d, vec_of(202));
    send_vec(vec_of(203), 0, 5'd0, r);
    check("R7 restart at slot0", 96'(r), 96'd0);
    read_imm(4'd0, d); check("R7 slot0 data", d, vec_of(203));
    send_vec(vec_of(204), 0, 5'd0, r);
    check("R7 second slot completes", 96'(r), 96'd1);

    // R8 load on the completing cycle
    load_idx(5'd5);
    read_store(4'd3, saved);
    send_vec(vec_of(300), 1, 5'd3, r);
    read_store(4'd5, d); check("R8 old index used", d, vec_of(300));
    check("R8 load wins", 96'(idx), 96'd3);
    read_store(4'd3, d); check("R8 loaded entry untouched", d, saved);

    // R1 load between words leaves the word count alone
    write_word(32'hDEADBEEF);
    write_word(32'h01234567);
    load_idx(5'd7);
    write_word(32'h89ABCDEF);
    read_store(4'd7, d);
    check("R1 count kept across load", d, {24'hABCDEF, 24'h456789, 24'hEF0123, 24'hDEADBE});
    check("R1 idx stepped", 96'(idx), 96'd8);

    // R5 invalid index
    load_idx(5'd20);
    read_store(4'd4, saved);
    max_attr = 4'd0;
    send_vec(vec_of(400), 0, 5'd0, r);
    check("R5 err set", 96'(err), 96'd1);
    check("R5 idx unchanged", 96'(idx), 96'd20);
    check("R5 no ready", 96'(r), 96'd0);
    read_store(4'd4, d); check("R5 store unchanged", d, saved);
    load_idx(5'd2);
    send_vec(vec_of(401), 0, 5'd0, r);
    check("R5 err sticky", 96'(err), 96'd1);
    read_store(4'd2, d); check("R4 write after error", d, vec_of(401));

    // R9 reset clears everything again
    do_reset();
    @(negedge clk);
    check("R9 idx cleared", 96'(idx), 96'd0);
    check("R9 err cleared", 96'(err), 96'd0);
    read_store(4'd2, d); check("R9 store cleared", d, 96'd0);
    read_imm(4'd0, d);   check("R9 imm cleared", d, 96'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule